// File: doc/BRIEF.md
# Word-Aligned Instruction Fetch Unit

This block is the front end of a single-cycle core. It holds the program counter and computes the address of the next instruction. It also contains an idealised instruction memory that returns the word at the current fetch address within the same cycle. The counter keeps only the word part of the address: 30 bits that stand for byte-address bits 31:2. The 32-bit fetch address shown to the rest of the core is that value with two zero bits appended below it.

On every rising clock edge the counter takes one of three values: the next word, a branch target, or a jump target. The branch target is the current counter plus one plus the sign-extended 16-bit immediate held in bits 15:0 of the fetched word. One adder with its carry-in tied high produces both the sequential value and the branch target, because only its second operand changes between the two cases. The jump target keeps the top four bits of the incremented counter and takes the lower 26 bits from bits 25:0 of the fetched word. The instruction memory is filled through a write port that is separate from the fetch path.

Top module: `ifu_fetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge, the counter becomes zero, so `iaddr_o` reads 0. The `take_branch_i`, `zero_i` and `jump_i` inputs have no effect in that cycle.
- R2: `iaddr_o` always equals the 30-bit word counter followed by two zero bits. Its bits 1:0 are never nonzero.
- R3: If `jump_i` is 0, and either `take_branch_i` or `zero_i` is 0, the counter advances by one word at the edge, so `iaddr_o` grows by 4.
- R4: If `jump_i` is 0 and both `take_branch_i` and `zero_i` are 1, the next counter is the current counter plus 1 plus the immediate from `instr_o[15:0]`. The immediate is used in word units with no extra shift.
- R5: The branch immediate is sign-extended from bit 15, so values 0x8000 to 0xFFFF move the counter backwards.
- R6: If `jump_i` is 1, the next counter takes bits 29:26 of (counter + 1) as its top four bits and `instr_o[25:0]` as its lower 26 bits.
- R7: `jump_i` overrides a branch that would otherwise be taken.
- R8: All counter arithmetic wraps modulo 2^30, and there is no overflow indication. One word past 0x3FFFFFFF is 0. A jump taken at 0x3FFFFFFF therefore gets 0 as its upper four bits.
- R9: `instr_o` is the memory word at index `iaddr_o[IMEM_AW+1:2]`. A write through the load port is visible in `instr_o` from the edge on which it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter and the memory write both update on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the counter |
| take_branch_i | input | 1 | The decoded instruction is a conditional branch |
| zero_i | input | 1 | Equality result from the execution stage |
| jump_i | input | 1 | The decoded instruction is an unconditional jump |
| load_we_i | input | 1 | Write enable of the instruction-memory load port |
| load_addr_i | input | IMEM_AW | Word index written by the load port |
| load_data_i | input | 32 | Word written by the load port |
| iaddr_o | output | 32 | Byte fetch address; the two low bits are always zero |
| instr_o | output | 32 | Instruction word at the current fetch address |

## Verification
Properties inside the design check four things on every clock edge. Reset forces address zero. The address grows by exactly 4 when no redirect is requested. A taken branch moves it by the scaled, sign-extended immediate. A jump splices the incremented upper nibble onto the target. Two things are left to the bench scenarios: the wrap past the top of the 30-bit space, and a memory write that lands on the word being fetched. The bench also walks an instruction sequence that mixes forward and backward branches, untaken branches, jumps whose upper nibble is nonzero, and a jump that competes with a taken branch.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    localparam int unsigned INSTR_W  = 32;
    localparam int unsigned BYTE_OFS = 2;
    localparam int unsigned PC_W     = INSTR_W - BYTE_OFS;
    localparam int unsigned IMM_W    = 16;
    localparam int unsigned TGT_W    = 26;

    typedef logic [PC_W-1:0]    word_addr_t;
    typedef logic [INSTR_W-1:0] instr_t;

    typedef struct packed {
        word_addr_t pc;
    } fetch_state_t;
endpackage

// File: rtl/ifu_imem.sv
module ifu_imem #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Combinational read: the address settles, then the data follows.
    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifu_pkg::*;
(
    input  word_addr_t       pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [TGT_W-1:0] target_i,
    input  logic             take_branch_i,
    input  logic             zero_i,
    input  logic             jump_i,
    output word_addr_t       pc_next_o
);
    localparam int unsigned EXT_W = PC_W - IMM_W;
    localparam int unsigned HI_W  = PC_W - TGT_W;

    logic       redirect;
    word_addr_t offset;
    word_addr_t add_b;
    word_addr_t add_sum;
    word_addr_t incr;
    word_addr_t jump_pc;

    always_comb begin
        redirect = take_branch_i & zero_i;
        offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        add_b    = redirect ? offset : '0;
        // One adder, carry-in tied high: pc + 1 or pc + 1 + offset.
        add_sum  = pc_i + add_b + word_addr_t'(1);
        incr     = pc_i + word_addr_t'(1);
    end

    generate
        if (HI_W > 0) begin : g_splice
            assign jump_pc = {incr[PC_W-1 -: HI_W], target_i};
        end else begin : g_target_only
            assign jump_pc = target_i[PC_W-1:0];
        end
    endgenerate

    assign pc_next_o = jump_i ? jump_pc : add_sum;
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
    import ifu_pkg::*;
#(
    parameter int unsigned IMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take_branch_i,
    input  logic               zero_i,
    input  logic               jump_i,
    input  logic               load_we_i,
    input  logic [IMEM_AW-1:0] load_addr_i,
    input  logic [31:0]        load_data_i,
    output logic [31:0]        iaddr_o,
    output logic [31:0]        instr_o
);
    fetch_state_t st_d, st_q;
    word_addr_t   pc_next;
    instr_t       fetched;

    ifu_imem #(.AW(IMEM_AW), .DW(INSTR_W)) u_imem (
        .clk     (clk),
        .we_i    (load_we_i),
        .waddr_i (load_addr_i),
        .wdata_i (load_data_i),
        .raddr_i (st_q.pc[IMEM_AW-1:0]),
        .rdata_o (fetched)
    );

    ifu_next_pc u_next (
        .pc_i          (st_q.pc),
        .imm_i         (fetched[IMM_W-1:0]),
        .target_i      (fetched[TGT_W-1:0]),
        .take_branch_i (take_branch_i),
        .zero_i        (zero_i),
        .jump_i        (jump_i),
        .pc_next_o     (pc_next)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = pc_next;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign iaddr_o = {st_q.pc, {BYTE_OFS{1'b0}}};
    assign instr_o = fetched;

    // Byte-level view of the targets, built from the ports only.
    logic [31:0] a_plus4;
    logic [31:0] a_boff;
    assign a_plus4 = iaddr_o + 32'd4;
    assign a_boff  = {{14{instr_o[15]}}, instr_o[15:0], 2'b00};

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (iaddr_o == 32'd0));

    p_step_word_r3: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && !(take_branch_i && zero_i)) |=> (iaddr_o == $past(a_plus4)));

    p_branch_target_r4: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && take_branch_i && zero_i) |=> (iaddr_o == $past(a_plus4 + a_boff)));

    p_jump_splice_r6: assert property (@(posedge clk) disable iff (rst)
        jump_i |=> (iaddr_o[27:2] == $past(instr_o[25:0])
                    && iaddr_o[31:28] == $past(a_plus4[31:28])));

    p_align_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (iaddr_o[1:0] == $past(iaddr_o[1:0])));
endmodule

// File: tb/tb_ifu_fetch_unit.sv
module tb_ifu_fetch_unit;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          take_branch_i = 1'b0;
    logic          zero_i = 1'b0;
    logic          jump_i = 1'b0;
    logic          load_we_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic [31:0]   load_data_i = '0;
    logic [31:0]   iaddr_o;
    logic [31:0]   instr_o;

    ifu_fetch_unit #(.IMEM_AW(AW)) dut (
        .clk(clk), .rst(rst), .take_branch_i(take_branch_i), .zero_i(zero_i),
        .jump_i(jump_i), .load_we_i(load_we_i), .load_addr_i(load_addr_i),
        .load_data_i(load_data_i), .iaddr_o(iaddr_o), .instr_o(instr_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] word;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model_mem [DEPTH];
    logic [29:0] model_pc = '0;
    bit          done = 0;

    function automatic logic [29:0] ref_next(input logic [29:0] pc, input logic [31:0] w,
                                             input logic b, input logic j, input logic z);
        logic [29:0] inc;
        inc = pc + 30'd1;
        if (j) return {inc[29:26], w[25:0]};
        if (b && z) return pc + 30'd1 + {{14{w[15]}}, w[15:0]};
        return inc;
    endfunction

    task automatic check(input logic [31:0] a, input logic [31:0] w, input exp_t e);
        n_checks++;
        if (a !== e.addr || w !== e.word) begin
            n_fail++;
            $display("FAIL %s: iaddr=%h instr=%h expected iaddr=%h instr=%h",
                     e.tag, a, w, e.addr, e.word);
        end
    endtask

    // Monitor: pops one expected item per cycle, sampled on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) check(iaddr_o, instr_o, sb_q.pop_front());
        end
    end

    task automatic load(input int a, input logic [31:0] d);
        @(negedge clk);
        load_we_i = 1'b1; load_addr_i = AW'(a); load_data_i = d;
        model_mem[a] = d;
        @(negedge clk);
        load_we_i = 1'b0;
    endtask

    // Driver: applies one cycle of controls and queues the predicted fetch.
    task automatic step(input logic b, input logic j, input logic z,
                        input logic ld, input int la, input logic [31:0] ldd,
                        input string tag);
        logic [29:0] nxt;
        exp_t e;
        @(negedge clk);
        rst = 1'b0;
        take_branch_i = b; jump_i = j; zero_i = z;
        load_we_i = ld; load_addr_i = AW'(la); load_data_i = ldd;
        nxt = ref_next(model_pc, model_mem[model_pc[AW-1:0]], b, j, z);
        @(posedge clk);
        #1;
        if (ld) model_mem[la] = ldd;
        model_pc = nxt;
        e.addr = {model_pc, 2'b00};
        e.word = model_mem[model_pc[AW-1:0]];
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic reset_pulse();
        exp_t e;
        @(negedge clk);
        rst = 1'b1; take_branch_i = 1'b1; jump_i = 1'b1; zero_i = 1'b1;
        load_we_i = 1'b0;
        @(posedge clk);
        #1;
        model_pc = '0;
        e.addr = 32'd0; e.word = model_mem[0]; e.tag = "R1";
        sb_q.push_back(e);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t e;
        // Fill memory while reset holds the counter at zero.
        for (int k = 0; k < DEPTH; k++) load(k, 32'h0C00_0000 | (k * 32'h0001_0203));
        load(0,  32'h1000_0005);
        load(8,  32'h1000_FFFC);
        load(5,  {6'h02, 26'h000_002A});
        load(42, {6'h02, 26'h000_0010});
        load(16, 32'h1000_FFE0);
        load(49, {6'h02, 26'h000_0033});
        load(52, {6'h02, 26'h3FF_FFFF});

        @(negedge clk);
        e.addr = 32'd0; e.word = model_mem[0]; e.tag = "R1 R2";
        check(iaddr_o, instr_o, e);

        step(1, 0, 1, 0, 0, 0, "R4");   // 0 -> 6, forward branch
        step(1, 0, 0, 0, 0, 0, "R3");   // branch without zero: sequential
        step(0, 0, 1, 0, 0, 0, "R3");   // zero without branch: sequential
        step(1, 0, 1, 0, 0, 0, "R5");   // 8 -> 5, negative offset
        step(0, 1, 0, 0, 0, 0, "R6");   // jump to 42
        step(1, 1, 1, 0, 0, 0, "R7");   // jump wins over taken branch
        step(1, 0, 1, 0, 0, 0, "R5");   // 16 -> 0x3FFFFFF1
        step(0, 1, 0, 0, 0, 0, "R6");   // upper nibble 0xF spliced
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, "R6");   // jump to 0x3FFFFFFF
        step(1, 0, 0, 1, 0, 32'h1000_0002, "R8 R9"); // wrap to 0, new word at 0
        step(1, 0, 1, 0, 0, 0, "R4");   // 0 -> 3 using the rewritten word
        reset_pulse();
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, "R6");

        @(negedge clk);
        take_branch_i = 0; jump_i = 0; zero_i = 0;
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule